// File: doc/BRIEF.md
# SD SPI Block Data Transfer Engine

This engine runs the data phase of SPI-mode memory-card transfers once a separate command engine has had a read or write command accepted. It talks to the card through a byte-exchange port: it presents one byte to send, and an external serial shifter returns the byte clocked in at the same time. On a read it polls for the start token, passes each block's data bytes to a byte stream and discards the two trailing check bytes. On a write it frames each block with a start token, pulls the data bytes from a valid/ready stream, appends two filler check bytes, reads the card's data-response byte and then polls until the card stops signalling busy.

One transfer carries one block or, in multi-block mode, the number of blocks on the block-count input. A block count of zero is treated as one. The engine also turns the host byte address into the argument the card expects: high-capacity cards take a block index, and standard cards take the byte address unchanged. Bounded polling on the start token and on busy ends a stuck transfer with an error code. A completion pulse reports the outcome, and the card select is released.

Top module: `sdblk_xfer`

## Requirements
- R1: One cycle after an accepted start, card_addr holds byte_addr shifted right by log2(BLOCK_BYTES) (9 for 512-byte blocks) when high_cap is 1, and byte_addr unchanged when high_cap is 0. It holds that value until the next start.
- R2: In a read, received bytes other than 0xFE are skipped while 0xFF is sent. The next BLOCK_BYTES received bytes after 0xFE appear on rd_data, one rd_valid pulse each. The two bytes after them are consumed and never appear on rd_data.
- R3: If TOKEN_POLLS received bytes in a row during the token hunt are not 0xFE, the transfer ends with err_code 1 after exactly TOKEN_POLLS exchanges, with no rd_valid and with cs_n high.
- R4: Each write block starts with token 0xFE in single-block mode and 0xFC in multi-block mode.
- R5: Each written block sends BLOCK_BYTES bytes taken in order from wr_data/wr_valid/wr_ready, followed by 0xFF 0xFF.
- R6: The byte received after the check bytes is masked to its low 5 bits. The masked value 0x05 means accepted (err_code 0). 0x0B gives err_code 3, 0x0D gives err_code 4, and any other value gives err_code 5. The upper three bits have no effect.
- R7: After each response byte the engine sends 0xFF until it receives 0xFF. After BUSY_POLLS received bytes in a row that are not 0xFF, it ends with err_code 2 and cs_n high, and sends no further token.
- R8: A multi-block write ends at the first block not accepted or after the last block, and then sends the stop token 0xFD. A single-block write never sends 0xFD.
- R9: stop_req pulses together with done only at the end of a multi-block read with err_code 0. It tells the command engine to issue the stop command (index 12, argument 0).
- R10: cs_n is high in reset and between transfers, and stays low from the cycle after start until the transfer ends. done pulses for one cycle with cs_n already high, and err_code 0 reports success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (accepted when idle) |
| is_write | input | 1 | 1 for write, 0 for read |
| multi | input | 1 | Multi-block mode |
| high_cap | input | 1 | Card uses block addressing |
| byte_addr | input | ADDR_W | Host byte address |
| block_count | input | CNT_W | Blocks in a multi-block transfer |
| card_addr | output | ADDR_W | Address argument for the card |
| cs_n | output | 1 | Card select, active low |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 3 | Outcome: 0 ok, 1 token timeout, 2 busy timeout, 3 check reject, 4 write reject, 5 unknown response |
| stop_req | output | 1 | Stop command needed after multi-block read |
| xfer_req | output | 1 | Byte exchange requested |
| xfer_tx | output | 8 | Byte to send |
| xfer_ack | input | 1 | Exchange complete, xfer_rx valid |
| xfer_rx | input | 8 | Byte received |
| wr_data | input | 8 | Write stream data |
| wr_valid | input | 1 | Write stream data valid |
| wr_ready | output | 1 | Write byte consumed |
| rd_data | output | 8 | Read stream data |
| rd_valid | output | 1 | Read byte valid |

## Verification
card_addr is due on the clock edge after start is sampled. Each rd_valid and wr_ready falls in the same cycle as the xfer_ack of its exchange. done, err_code and stop_req are due one edge after the ack of the final exchange. The bench card model raises xfer_ack on a falling edge and samples every output two time units later, while the design's state still belongs to that exchange. The model tallies each byte the engine sends by position in the frame, so token values, data order, check bytes, fill bytes and poll counts are compared against counts derived from the requirements.

// File: rtl/sdblk_pkg.sv
package sdblk_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_R_HUNT, ST_R_DATA, ST_R_CRC,
        ST_W_TOKEN, ST_W_DATA, ST_W_CRC, ST_W_RESP, ST_W_BUSY, ST_W_STOP
    } xfer_state_e;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_TOK_TMO  = 3'd1,
        ERR_BUSY_TMO = 3'd2,
        ERR_CRC_REJ  = 3'd3,
        ERR_WR_REJ   = 3'd4,
        ERR_BAD_RESP = 3'd5
    } err_code_e;

    typedef struct packed {
        logic is_wr;
        logic multi;
    } job_t;

    localparam logic [7:0] TOK_SINGLE = 8'hFE;
    localparam logic [7:0] TOK_MULTI  = 8'hFC;
    localparam logic [7:0] TOK_STOP   = 8'hFD;
    localparam logic [7:0] FILL_BYTE  = 8'hFF;
    localparam logic [4:0] RESP_OK    = 5'h05;
    localparam logic [4:0] RESP_CRC   = 5'h0B;
    localparam logic [4:0] RESP_WR    = 5'h0D;

    function automatic err_code_e classify_resp(logic [4:0] r);
        case (r)
            RESP_OK:  return ERR_NONE;
            RESP_CRC: return ERR_CRC_REJ;
            RESP_WR:  return ERR_WR_REJ;
            default:  return ERR_BAD_RESP;
        endcase
    endfunction

endpackage

// File: rtl/sdblk_addr.sv
module sdblk_addr #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned SHIFT  = 9
) (
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic              high_cap,
    output logic [ADDR_W-1:0] card_addr
);
    assign card_addr = high_cap ? (byte_addr >> SHIFT) : byte_addr;
endmodule

// File: rtl/sdblk_wait_ctr.sv
module sdblk_wait_ctr #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    output logic expired
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign expired = tick && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clear || expired) cnt <= '0;
        else if (tick)               cnt <= cnt + 1'b1;
    end

    // R3 / R7: poll counter never runs past its limit
    assert_ctr_bound_R3: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(LIMIT));
endmodule

// File: rtl/sdblk_xfer.sv
module sdblk_xfer
    import sdblk_pkg::*;
#(
    parameter int unsigned BLOCK_BYTES = 512,
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned TOKEN_POLLS = 100000,
    parameter int unsigned BUSY_POLLS  = 1000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              is_write,
    input  logic              multi,
    input  logic              high_cap,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic [CNT_W-1:0]  block_count,
    output logic [ADDR_W-1:0] card_addr,
    output logic              cs_n,
    output logic              done,
    output logic [2:0]        err_code,
    output logic              stop_req,
    output logic              xfer_req,
    output logic [7:0]        xfer_tx,
    input  logic              xfer_ack,
    input  logic [7:0]        xfer_rx,
    input  logic [7:0]        wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic [7:0]        rd_data,
    output logic              rd_valid
);
    localparam int unsigned IDX_W = $clog2(BLOCK_BYTES);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BLOCK_BYTES - 1);

    xfer_state_e       st;
    job_t              job;
    logic [IDX_W-1:0]  idx;
    logic [CNT_W-1:0]  blk_left;
    logic [4:0]        resp_q;
    err_code_e         err_pend, err_q;
    logic [ADDR_W-1:0] addr_next;
    logic              tok_tick, tok_exp, busy_tick, busy_exp, last_blk;

    sdblk_addr #(.ADDR_W(ADDR_W), .SHIFT(IDX_W)) u_addr (
        .byte_addr(byte_addr), .high_cap(high_cap), .card_addr(addr_next));

    assign tok_tick  = (st == ST_R_HUNT) && xfer_ack && (xfer_rx != TOK_SINGLE);
    assign busy_tick = (st == ST_W_BUSY) && xfer_ack && (xfer_rx != FILL_BYTE);

    sdblk_wait_ctr #(.LIMIT(TOKEN_POLLS)) u_tok_wait (
        .clk(clk), .rst(rst), .clear(st != ST_R_HUNT), .tick(tok_tick), .expired(tok_exp));
    sdblk_wait_ctr #(.LIMIT(BUSY_POLLS)) u_busy_wait (
        .clk(clk), .rst(rst), .clear(st != ST_W_BUSY), .tick(busy_tick), .expired(busy_exp));

    assign last_blk = (blk_left <= CNT_W'(1));
    assign cs_n     = (st == ST_IDLE);
    assign xfer_req = (st != ST_IDLE) && ((st != ST_W_DATA) || wr_valid);
    assign wr_ready = (st == ST_W_DATA) && xfer_ack;
    assign rd_valid = (st == ST_R_DATA) && xfer_ack;
    assign rd_data  = xfer_rx;
    assign err_code = err_q;

    always_comb begin
        case (st)
            ST_W_TOKEN: xfer_tx = job.multi ? TOK_MULTI : TOK_SINGLE;
            ST_W_DATA:  xfer_tx = wr_data;
            ST_W_STOP:  xfer_tx = TOK_STOP;
            default:    xfer_tx = FILL_BYTE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            job       <= '0;
            idx       <= '0;
            blk_left  <= '0;
            resp_q    <= '0;
            err_pend  <= ERR_NONE;
            err_q     <= ERR_NONE;
            done      <= 1'b0;
            stop_req  <= 1'b0;
            card_addr <= '0;
        end else begin
            done     <= 1'b0;
            stop_req <= 1'b0;
            if (st == ST_IDLE) begin
                if (start) begin
                    card_addr <= addr_next;
                    job       <= '{is_wr: is_write, multi: multi};
                    blk_left  <= multi ? block_count : CNT_W'(1);
                    err_pend  <= ERR_NONE;
                    err_q     <= ERR_NONE;
                    idx       <= '0;
                    st        <= is_write ? ST_W_TOKEN : ST_R_HUNT;
                end
            end else if (xfer_ack) begin
                case (st)
                    ST_R_HUNT: begin
                        if (xfer_rx == TOK_SINGLE) begin
                            idx <= '0;
                            st  <= ST_R_DATA;
                        end else if (tok_exp) begin
                            err_q <= ERR_TOK_TMO;
                            done  <= 1'b1;
                            st    <= ST_IDLE;
                        end
                    end
                    ST_R_DATA: begin
                        idx <= (idx == IDX_LAST) ? '0 : idx + 1'b1;
                        if (idx == IDX_LAST) st <= ST_R_CRC;
                    end
                    ST_R_CRC: begin
                        idx <= idx[0] ? '0 : idx + 1'b1;
                        if (idx[0]) begin
                            if (last_blk) begin
                                done     <= 1'b1;
                                stop_req <= job.multi;
                                st       <= ST_IDLE;
                            end else begin
                                blk_left <= blk_left - 1'b1;
                                st       <= ST_R_HUNT;
                            end
                        end
                    end
                    ST_W_TOKEN: begin
                        idx <= '0;
                        st  <= ST_W_DATA;
                    end
                    ST_W_DATA: begin
                        idx <= (idx == IDX_LAST) ? '0 : idx + 1'b1;
                        if (idx == IDX_LAST) st <= ST_W_CRC;
                    end
                    ST_W_CRC: begin
                        idx <= idx[0] ? '0 : idx + 1'b1;
                        if (idx[0]) st <= ST_W_RESP;
                    end
                    ST_W_RESP: begin
                        resp_q <= xfer_rx[4:0];
                        st     <= ST_W_BUSY;
                    end
                    ST_W_BUSY: begin
                        if (xfer_rx == FILL_BYTE) begin
                            if (resp_q != RESP_OK) begin
                                if (job.multi) begin
                                    err_pend <= classify_resp(resp_q);
                                    st       <= ST_W_STOP;
                                end else begin
                                    err_q <= classify_resp(resp_q);
                                    done  <= 1'b1;
                                    st    <= ST_IDLE;
                                end
                            end else if (last_blk) begin
                                if (job.multi) st <= ST_W_STOP;
                                else begin
                                    done <= 1'b1;
                                    st   <= ST_IDLE;
                                end
                            end else begin
                                blk_left <= blk_left - 1'b1;
                                st       <= ST_W_TOKEN;
                            end
                        end else if (busy_exp) begin
                            err_q <= ERR_BUSY_TMO;
                            done  <= 1'b1;
                            st    <= ST_IDLE;
                        end
                    end
                    ST_W_STOP: begin
                        err_q <= err_pend;
                        done  <= 1'b1;
                        st    <= ST_IDLE;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    // R10: completion is reported with the card already released
    assert_done_release_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> cs_n);
    // R2: read bytes only flow while the card is selected
    assert_rd_selected_R2: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !cs_n);
    // R9: stop request only at the end of a multi-block read
    assert_stop_read_R9: assert property (@(posedge clk) disable iff (rst)
        stop_req |-> (done && !job.is_wr && job.multi));
    // R4: a pending token or filler byte stays put until exchanged
    assert_tx_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && !xfer_ack && st != ST_W_DATA) |=> (xfer_req && $stable(xfer_tx)));
    // R5: a write byte is consumed only while it is being sent
    assert_wr_beat_R5: assert property (@(posedge clk) disable iff (rst)
        wr_ready |-> (xfer_req && wr_valid && xfer_tx == wr_data));
    // R10: at most one stream or completion event per cycle
    assert_single_event_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_valid, wr_ready, done}));
endmodule

// File: tb/tb_sdblk_xfer.sv
module tb_sdblk_xfer;
    localparam int CLK_PERIOD = 10;
    localparam int BLK  = 512;
    localparam int TPOL = 20;
    localparam int BPOL = 30;

    typedef struct packed {
        bit        wr;
        bit        multi;
        bit        hc;
        bit [31:0] addr;
        bit [7:0]  nblk;
        bit [7:0]  pre;
        bit [7:0]  busy;
        bit [7:0]  r0;
        bit [7:0]  r1;
        bit [7:0]  r2;
        bit [2:0]  eerr;
        bit [7:0]  eblk;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b0, 1'b0, 32'h0000_1234, 8'd1, 8'd3, 8'd0, 8'h00, 8'h00, 8'h00, 3'd0, 8'd1},
        '{1'b0, 1'b1, 1'b1, 32'h0004_0000, 8'd3, 8'd5, 8'd0, 8'h00, 8'h00, 8'h00, 3'd0, 8'd3},
        '{1'b1, 1'b0, 1'b0, 32'h0000_0400, 8'd1, 8'd0, 8'd4, 8'hE5, 8'h00, 8'h00, 3'd0, 8'd1},
        '{1'b1, 1'b1, 1'b1, 32'h0000_0A00, 8'd3, 8'd0, 8'd2, 8'h05, 8'h05, 8'h05, 3'd0, 8'd3},
        '{1'b1, 1'b1, 1'b0, 32'h0000_0200, 8'd3, 8'd0, 8'd1, 8'h05, 8'h0B, 8'h05, 3'd3, 8'd2},
        '{1'b1, 1'b0, 1'b1, 32'h0000_1FFF, 8'd1, 8'd0, 8'd0, 8'h0D, 8'h00, 8'h00, 3'd4, 8'd1},
        '{1'b1, 1'b0, 1'b0, 32'h8000_0000, 8'd1, 8'd0, 8'd3, 8'h07, 8'h00, 8'h00, 3'd5, 8'd1},
        '{1'b0, 1'b0, 1'b1, 32'hFFFF_FE00, 8'd1, 8'd0, 8'd0, 8'h00, 8'h00, 8'h00, 3'd0, 8'd1}
    };

    logic        clk = 1'b0, rst = 1'b1;
    logic        start = 1'b0, is_write = 1'b0, multi = 1'b0, high_cap = 1'b0;
    logic [31:0] byte_addr = '0;
    logic [15:0] block_count = '0;
    logic [31:0] card_addr;
    logic        cs_n, done, stop_req, xfer_req, wr_ready, rd_valid;
    logic [2:0]  err_code;
    logic [7:0]  xfer_tx, rd_data;
    logic        xfer_ack = 1'b0;
    logic [7:0]  xfer_rx = 8'hFF;
    logic [7:0]  wr_data = '0;
    logic        wr_valid = 1'b0;

    sdblk_xfer #(.BLOCK_BYTES(BLK), .ADDR_W(32), .CNT_W(16),
                 .TOKEN_POLLS(TPOL), .BUSY_POLLS(BPOL)) dut (
        .clk(clk), .rst(rst), .start(start), .is_write(is_write), .multi(multi),
        .high_cap(high_cap), .byte_addr(byte_addr), .block_count(block_count),
        .card_addr(card_addr), .cs_n(cs_n), .done(done), .err_code(err_code),
        .stop_req(stop_req), .xfer_req(xfer_req), .xfer_tx(xfer_tx),
        .xfer_ack(xfer_ack), .xfer_rx(xfer_rx), .wr_data(wr_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid));

    int checks = 0, errors = 0;

    // card model state
    bit       m_write, m_never_tok, m_stuck;
    int       m_pre, m_busy, m_phase, m_pos, m_blk, m_dcnt;
    bit [7:0] m_resp [3];
    bit [7:0] m_tok;
    int       tok_cnt, tok_bad, data_bad, crc_bad, fill_bad, fd_cnt, hunt_polls, busy_polls;
    // monitor state
    int       rd_cnt, rd_bad, stop_cnt, wr_k;
    bit       done_seen, adv;
    bit [2:0] got_err;

    function automatic bit [7:0] rpat(int b, int i);
        return 8'((b * 5 + i * 3 + 7) & 255);
    endfunction
    function automatic bit [7:0] wpat(int k);
        return 8'((k * 7 + 3) & 255);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic card_step(input bit [7:0] tx, output bit [7:0] rx);
        rx = 8'hFF;
        if (!m_write) begin
            case (m_phase)
                0: begin
                    hunt_polls++;
                    if (tx != 8'hFF) fill_bad++;
                    if (m_never_tok || m_pos < m_pre) m_pos++;
                    else begin rx = 8'hFE; m_phase = 1; m_pos = 0; end
                end
                1: begin
                    rx = rpat(m_blk, m_pos); m_pos++;
                    if (m_pos == BLK) begin m_phase = 2; m_pos = 0; end
                end
                default: begin
                    rx = (m_pos == 0) ? 8'hA5 : 8'h5A; m_pos++;
                    if (m_pos == 2) begin m_phase = 0; m_pos = 0; m_blk++; end
                end
            endcase
        end else begin
            case (m_phase)
                0: begin
                    if (tx == 8'hFD) fd_cnt++;
                    else if (tx == m_tok) begin tok_cnt++; m_phase = 1; m_pos = 0; end
                    else tok_bad++;
                end
                1: begin
                    if (tx != wpat(m_dcnt)) data_bad++;
                    m_dcnt++; m_pos++;
                    if (m_pos == BLK) begin m_phase = 2; m_pos = 0; end
                end
                2: begin
                    if (tx != 8'hFF) crc_bad++;
                    m_pos++;
                    if (m_pos == 2) m_phase = 3;
                end
                3: begin
                    if (tx != 8'hFF) fill_bad++;
                    rx = m_resp[m_blk > 2 ? 2 : m_blk]; m_phase = 4; m_pos = 0;
                end
                default: begin
                    busy_polls++;
                    if (tx != 8'hFF) fill_bad++;
                    if (m_stuck || m_pos < m_busy) begin rx = 8'h00; m_pos++; end
                    else begin m_phase = 0; m_blk++; end
                end
            endcase
        end
    endtask

    initial forever #(CLK_PERIOD / 2) clk = ~clk;

    // card model and output monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst) xfer_ack = 1'b0;
            else if (xfer_ack) xfer_ack = 1'b0;
            else if (xfer_req) begin
                bit [7:0] r;
                card_step(xfer_tx, r);
                xfer_rx  = r;
                xfer_ack = 1'b1;
            end
            #2;
            if (rd_valid) begin
                if (rd_data !== rpat(rd_cnt / BLK, rd_cnt % BLK)) rd_bad++;
                rd_cnt++;
            end
            if (wr_ready) adv = 1'b1;
            if (done) begin done_seen = 1'b1; got_err = err_code; end
            if (stop_req) stop_cnt++;
            if (adv) begin
                @(posedge clk); #1;
                wr_k++;
                wr_data = wpat(wr_k);
                adv = 1'b0;
            end
        end
    end

    task automatic summary_and_end();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements): actual=hung expected=finished");
        summary_and_end();
    end

    task automatic run(input vec_t v, input bit never_tok, input bit stuck);
        m_write = v.wr; m_never_tok = never_tok; m_stuck = stuck;
        m_pre = v.pre; m_busy = v.busy; m_phase = 0; m_pos = 0; m_blk = 0; m_dcnt = 0;
        m_resp[0] = v.r0; m_resp[1] = v.r1; m_resp[2] = v.r2;
        m_tok = v.multi ? 8'hFC : 8'hFE;
        tok_cnt = 0; tok_bad = 0; data_bad = 0; crc_bad = 0; fill_bad = 0; fd_cnt = 0;
        hunt_polls = 0; busy_polls = 0; rd_cnt = 0; rd_bad = 0; stop_cnt = 0;
        done_seen = 0; got_err = 0; wr_k = 0; wr_data = wpat(0); wr_valid = v.wr;
        @(posedge clk); #1;
        start = 1'b1; is_write = v.wr; multi = v.multi; high_cap = v.hc;
        byte_addr = v.addr; block_count = 16'(v.nblk);
        @(posedge clk); #1;
        start = 1'b0; byte_addr = 32'h5555_5555;
        chk(cs_n == 1'b0, "R10", "cs_n low during transfer", cs_n, 0);
        begin
            int t = 0;
            while (!done_seen && t < 20000) begin @(posedge clk); t++; end
        end
        chk(done_seen, "R10", "done pulse seen", done_seen, 1);
        #3;
        chk(cs_n == 1'b1, "R10", "cs_n high after done", cs_n, 1);
        wr_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #3;
        chk(cs_n == 1'b1, "R10", "reset cs_n", cs_n, 1);
        chk(xfer_req == 1'b0 && done == 1'b0, "R10", "reset req/done", {xfer_req, done}, 0);
        chk(card_addr == 32'd0 && err_code == 3'd0, "R1", "reset addr/err", card_addr, 0);
        @(negedge clk); rst = 1'b0;

        for (int i = 0; i < 8; i++) begin
            vec_t v = VECS[i];
            bit [31:0] ea = v.hc ? (v.addr >> 9) : v.addr;
            run(v, 1'b0, 1'b0);
            chk(card_addr == ea, "R1", "card address", card_addr, ea);
            chk(got_err == v.eerr, "R6", "err_code", got_err, v.eerr);
            if (!v.wr) begin
                chk(rd_cnt == int'(v.eblk) * BLK && rd_bad == 0, "R2", "read bytes/mismatches",
                    rd_cnt * 1000 + rd_bad, int'(v.eblk) * BLK * 1000);
                chk(fill_bad == 0, "R2", "hunt fill bytes", fill_bad, 0);
                chk(stop_cnt == (v.multi ? 1 : 0), "R9", "stop request", stop_cnt, v.multi ? 1 : 0);
            end else begin
                chk(tok_cnt == int'(v.eblk) && tok_bad == 0, "R4", "block tokens",
                    tok_cnt * 100 + tok_bad, int'(v.eblk) * 100);
                chk(m_dcnt == int'(v.eblk) * BLK && data_bad == 0, "R5", "write data",
                    m_dcnt * 1000 + data_bad, int'(v.eblk) * BLK * 1000);
                chk(crc_bad == 0, "R5", "check filler bytes", crc_bad, 0);
                chk(fill_bad == 0 && busy_polls == int'(v.eblk) * (int'(v.busy) + 1), "R7",
                    "busy polling", busy_polls * 100 + fill_bad, int'(v.eblk) * (int'(v.busy) + 1) * 100);
                chk(fd_cnt == (v.multi ? 1 : 0), "R8", "stop token count", fd_cnt, v.multi ? 1 : 0);
                chk(stop_cnt == 0, "R9", "no stop request on write", stop_cnt, 0);
            end
        end

        // R3: start token never arrives
        run('{1'b0, 1'b0, 1'b0, 32'h10, 8'd1, 8'd0, 8'd0, 8'h0, 8'h0, 8'h0, 3'd1, 8'd0}, 1'b1, 1'b0);
        chk(got_err == 3'd1, "R3", "token timeout code", got_err, 1);
        chk(hunt_polls == TPOL, "R3", "token polls", hunt_polls, TPOL);
        chk(rd_cnt == 0, "R3", "no read data", rd_cnt, 0);

        // R7: card stays busy in a multi-block write
        run('{1'b1, 1'b1, 1'b0, 32'h20, 8'd2, 8'd0, 8'd0, 8'h05, 8'h05, 8'h05, 3'd2, 8'd1}, 1'b0, 1'b1);
        chk(got_err == 3'd2, "R7", "busy timeout code", got_err, 2);
        chk(busy_polls == BPOL, "R7", "busy polls", busy_polls, BPOL);
        chk(fd_cnt == 0 && tok_cnt == 1, "R7", "no token after busy timeout", fd_cnt * 10 + tok_cnt, 1);

        summary_and_end();
    end
endmodule